// File: doc/BRIEF.md
# Load-Use Interlock for a Five-Stage Pipeline Front End

This block sits in the decode stage of a five-stage integer pipeline and stops the front end for a single cycle when the instruction in decode needs the result of a load that has just moved into the execute stage. A loaded value is not available early enough for execute to use in the cycle right after the load, so one bubble is inserted. After that single bubble, the forwarding network delivers the value.

The top module contains the three registers the interlock acts on:

- the program counter, which steps by 4 on each cycle without a stall;
- the fetch/decode register, which holds the fetched instruction word and a valid flag;
- the decode/execute control register, which holds the 9-bit control word and the destination register number.

The instruction memory is outside the block. It returns `fetch_instr_i` for the address on `pc_o`. Forwarding, the memories and the ALU are not part of this block.

An instruction word is `{op[1:0], rs, rt, rd}`, with each register field `REG_AW` bits wide. The op codes are:

| op | Class |
|----|-------|
| 0 | register-to-register (R-type) |
| 1 | load |
| 2 | store |
| 3 | branch |

All pins are plain control and data wires with no valid/ready handshake. A stall is the only form of back-pressure. While a stall is active, the block keeps presenting the same `pc_o`, and the fetched word from that cycle is dropped.

Top module: `load_use_interlock`

## Requirements
- R1: A stall is raised in any cycle in which all three of these hold: the execute-stage control word has its read-memory bit set, the decode stage holds a valid instruction, and the execute-stage destination register equals the decode instruction's rs or its rt.
- R2: When the execute-stage read-memory bit is 0, no stall is raised, even if register numbers match. This includes a register-to-register producer writing the same register.
- R3: On a stall cycle, the PC keeps its value at the next edge. On every other cycle after reset, it advances by `PC_STEP` (4).
- R4: On a stall cycle, the decode register keeps its instruction word at the next edge. Otherwise it loads `fetch_instr_i` and is marked valid.
- R5: On a stall cycle, the control word written into the execute stage is all zeros, which forms the bubble.
- R6: A stall lasts exactly one cycle. The bubble clears the read-memory bit, so the stall drops without any extra state.
- R7: The control word uses this bit order, from bit 8 down to bit 0:
  - bit 8: destination select
  - bit 7: ALU op high
  - bit 6: ALU op low
  - bit 5: immediate operand
  - bit 4: branch
  - bit 3: read memory
  - bit 2: write memory
  - bit 1: register write
  - bit 0: memory-to-register

  The values per class, with don't-cares driven to 0, are: R-type 9'b110000010, load 9'b000101011, store 9'b000100100, branch 9'b001010000. An invalid decode slot gives all zeros.
- R8: A synchronous reset clears the PC to 0, marks decode invalid, and clears the execute-stage control word and destination register.
- R9: `pc_we_o` and `ifid_we_o` are both the inverse of the stall, and `ctrl_zero_o` is the stall itself.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| fetch_instr_i | input | INSTR_W | Instruction word fetched at `pc_o` |
| pc_o | output | PC_W | Program counter |
| pc_we_o | output | 1 | PC write enable |
| ifid_we_o | output | 1 | Decode register write enable |
| ctrl_zero_o | output | 1 | Selects the zero control word into execute |
| id_instr_o | output | INSTR_W | Instruction word held in decode |
| id_valid_o | output | 1 | Decode slot holds a real instruction |
| ex_ctrl_o | output | 9 | Control word held in execute |
| ex_rt_o | output | REG_AW | Destination register held in execute |

## Verification
The bench builds the block with its default parameters: 5-bit register fields and a 32-bit PC that steps by 4. It sweeps every pairing of a load or register-to-register producer with each of the four consumer classes. For each pairing, the consumer's sources relate to the producer's destination in one of five ways: no match, rs only, rt only, both, or a match only in the rd field. This covers the dependent case that gives one bubble, the independent cases that give none, the R-type producer that must never stall, and load-to-load chains. A reference model in the bench is built from the requirements alone. It predicts the PC, the decode word, the execute control word and every enable in every cycle.

// File: rtl/lu_pkg.sv
package lu_pkg;
  localparam int CTRL_W = 9;

  // control word bit positions, bit 8 down to bit 0
  localparam int CB_DST_SEL = 8;
  localparam int CB_ALU_HI  = 7;
  localparam int CB_ALU_LO  = 6;
  localparam int CB_IMM     = 5;
  localparam int CB_BRANCH  = 4;
  localparam int CB_MEM_RD  = 3;
  localparam int CB_MEM_WR  = 2;
  localparam int CB_REG_WR  = 1;
  localparam int CB_MEM2REG = 0;

  typedef enum logic [1:0] {
    OP_RTYPE  = 2'd0,
    OP_LOAD   = 2'd1,
    OP_STORE  = 2'd2,
    OP_BRANCH = 2'd3
  } op_class_e;

  typedef logic [CTRL_W-1:0] ctrl_word_t;

  localparam ctrl_word_t CW_RTYPE  = 9'b110000010;
  localparam ctrl_word_t CW_LOAD   = 9'b000101011;
  localparam ctrl_word_t CW_STORE  = 9'b000100100;
  localparam ctrl_word_t CW_BRANCH = 9'b001010000;
endpackage

// File: rtl/lu_hold_reg.sv
module lu_hold_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (en) q <= d;
  end
endmodule

// File: rtl/lu_ctrl_decode.sv
module lu_ctrl_decode
  import lu_pkg::*;
(
  input  logic       valid,
  input  logic [1:0] op,
  output ctrl_word_t ctrl
);
  always_comb begin
    ctrl = '0;
    if (valid) begin
      unique case (op_class_e'(op))
        OP_RTYPE:  ctrl = CW_RTYPE;
        OP_LOAD:   ctrl = CW_LOAD;
        OP_STORE:  ctrl = CW_STORE;
        OP_BRANCH: ctrl = CW_BRANCH;
        default:   ctrl = '0;
      endcase
    end
  end
endmodule

// File: rtl/lu_hazard_detect.sv
module lu_hazard_detect #(
  parameter int REG_AW = 5
) (
  input  logic              ex_mem_rd,
  input  logic [REG_AW-1:0] ex_rt,
  input  logic              id_valid,
  input  logic [REG_AW-1:0] id_rs,
  input  logic [REG_AW-1:0] id_rt,
  output logic              stall
);
  logic hit_rs, hit_rt;
  assign hit_rs = (ex_rt == id_rs);
  assign hit_rt = (ex_rt == id_rt);
  assign stall  = ex_mem_rd & id_valid & (hit_rs | hit_rt);
endmodule

// File: rtl/load_use_interlock.sv
module load_use_interlock
  import lu_pkg::*;
#(
  parameter int REG_AW  = 5,
  parameter int PC_W    = 32,
  parameter int PC_STEP = 4,
  localparam int OP_W    = 2,
  localparam int INSTR_W = OP_W + 3 * REG_AW
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [INSTR_W-1:0] fetch_instr_i,
  output logic [PC_W-1:0]    pc_o,
  output logic               pc_we_o,
  output logic               ifid_we_o,
  output logic               ctrl_zero_o,
  output logic [INSTR_W-1:0] id_instr_o,
  output logic               id_valid_o,
  output logic [CTRL_W-1:0]  ex_ctrl_o,
  output logic [REG_AW-1:0]  ex_rt_o
);
  localparam int RD_LSB = 0;
  localparam int RT_LSB = REG_AW;
  localparam int RS_LSB = 2 * REG_AW;
  localparam int OP_LSB = 3 * REG_AW;
  localparam int IFID_W = INSTR_W + 1;
  localparam int IDEX_W = CTRL_W + REG_AW;

  logic              stall;
  logic [IFID_W-1:0] ifid_q;
  logic [IDEX_W-1:0] idex_q, idex_d;
  ctrl_word_t        dec_ctrl;
  logic [REG_AW-1:0] id_rs, id_rt;
  logic [OP_W-1:0]   id_op;

  // program counter
  lu_hold_reg #(.W(PC_W)) u_pc (
    .clk(clk), .rst(rst), .en(~stall),
    .d(pc_o + PC_W'(PC_STEP)), .q(pc_o)
  );

  // fetch/decode register: {valid, instruction}
  lu_hold_reg #(.W(IFID_W)) u_ifid (
    .clk(clk), .rst(rst), .en(~stall),
    .d({1'b1, fetch_instr_i}), .q(ifid_q)
  );

  assign id_valid_o = ifid_q[INSTR_W];
  assign id_instr_o = ifid_q[INSTR_W-1:0];
  assign id_op      = id_instr_o[OP_LSB +: OP_W];
  assign id_rs      = id_instr_o[RS_LSB +: REG_AW];
  assign id_rt      = id_instr_o[RT_LSB +: REG_AW];

  lu_ctrl_decode u_dec (
    .valid(id_valid_o), .op(id_op), .ctrl(dec_ctrl)
  );

  lu_hazard_detect #(.REG_AW(REG_AW)) u_haz (
    .ex_mem_rd(ex_ctrl_o[CB_MEM_RD]), .ex_rt(ex_rt_o),
    .id_valid(id_valid_o), .id_rs(id_rs), .id_rt(id_rt),
    .stall(stall)
  );

  // bubble mux feeding decode/execute
  assign idex_d = {(stall ? ctrl_word_t'('0) : dec_ctrl), id_rt};

  lu_hold_reg #(.W(IDEX_W)) u_idex (
    .clk(clk), .rst(rst), .en(1'b1), .d(idex_d), .q(idex_q)
  );

  assign ex_ctrl_o   = idex_q[REG_AW +: CTRL_W];
  assign ex_rt_o     = idex_q[REG_AW-1:0];
  assign pc_we_o     = ~stall;
  assign ifid_we_o   = ~stall;
  assign ctrl_zero_o = stall;

  logic unused_rd;
  assign unused_rd = ^id_instr_o[RD_LSB +: REG_AW];
endmodule

// File: rtl/load_use_interlock_chk.sv
module load_use_interlock_chk
  import lu_pkg::*;
#(
  parameter int REG_AW  = 5,
  parameter int PC_W    = 32,
  parameter int PC_STEP = 4,
  parameter int INSTR_W = 17
) (
  input logic               clk,
  input logic               rst,
  input logic [PC_W-1:0]    pc_o,
  input logic               pc_we_o,
  input logic               ifid_we_o,
  input logic               ctrl_zero_o,
  input logic [INSTR_W-1:0] id_instr_o,
  input logic [CTRL_W-1:0]  ex_ctrl_o
);
  assert_pc_hold_R3: assert property (@(posedge clk) disable iff (rst)
    ctrl_zero_o |=> $stable(pc_o));
  assert_pc_step_R3: assert property (@(posedge clk) disable iff (rst)
    !ctrl_zero_o |=> pc_o == $past(pc_o) + PC_W'(PC_STEP));
  assert_ifid_hold_R4: assert property (@(posedge clk) disable iff (rst)
    ctrl_zero_o |=> $stable(id_instr_o));
  assert_bubble_zero_R5: assert property (@(posedge clk) disable iff (rst)
    ctrl_zero_o |=> ex_ctrl_o == '0);
  assert_single_stall_R6: assert property (@(posedge clk) disable iff (rst)
    ctrl_zero_o |=> !ctrl_zero_o);
  assert_no_load_no_stall_R2: assert property (@(posedge clk) disable iff (rst)
    !ex_ctrl_o[CB_MEM_RD] |-> !ctrl_zero_o);
  assert_enables_agree_R9: assert property (@(posedge clk) disable iff (rst)
    (pc_we_o == ifid_we_o) && (pc_we_o != ctrl_zero_o));
endmodule

bind load_use_interlock load_use_interlock_chk #(
  .REG_AW(REG_AW), .PC_W(PC_W), .PC_STEP(PC_STEP), .INSTR_W(INSTR_W)
) u_chk (
  .clk(clk), .rst(rst), .pc_o(pc_o), .pc_we_o(pc_we_o),
  .ifid_we_o(ifid_we_o), .ctrl_zero_o(ctrl_zero_o),
  .id_instr_o(id_instr_o), .ex_ctrl_o(ex_ctrl_o)
);

// File: tb/test_load_use_interlock.sv
module test_load_use_interlock;
  localparam int CLK_PERIOD = 10;
  localparam int AW   = 5;
  localparam int PCW  = 32;
  localparam int IW   = 2 + 3 * AW;
  localparam int RUN  = 9;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [IW-1:0]  fetch_instr;
  logic [PCW-1:0] pc;
  logic           pc_we, ifid_we, czero, id_valid;
  logic [IW-1:0]  id_instr;
  logic [8:0]     ex_ctrl;
  logic [AW-1:0]  ex_rt;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  // current program: word 0 producer, word 1 consumer, filler after
  logic [IW-1:0] prog_prod, prog_cons;

  always #(CLK_PERIOD/2) clk = ~clk;

  load_use_interlock i_load_use_interlock (
    .clk(clk), .rst(rst), .fetch_instr_i(fetch_instr), .pc_o(pc),
    .pc_we_o(pc_we), .ifid_we_o(ifid_we), .ctrl_zero_o(czero),
    .id_instr_o(id_instr), .id_valid_o(id_valid),
    .ex_ctrl_o(ex_ctrl), .ex_rt_o(ex_rt)
  );

  function automatic logic [IW-1:0] mk(input int op, input int rs, input int rt, input int rd);
    return {op[1:0], rs[AW-1:0], rt[AW-1:0], rd[AW-1:0]};
  endfunction

  // filler uses registers far from the producer destination
  always_comb begin
    if (pc == 0)      fetch_instr = prog_prod;
    else if (pc == 4) fetch_instr = prog_cons;
    else              fetch_instr = mk(0, 28, 29, 30);
  end

  // R7 encodings from the requirement
  function automatic logic [8:0] cw(input logic v, input logic [1:0] op);
    if (!v) return 9'd0;
    case (op)
      2'd0: return 9'b110000010;
      2'd1: return 9'b000101011;
      2'd2: return 9'b000100100;
      default: return 9'b001010000;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h time=%0t", req, act, exp, $time);
    end
  endtask

  // reference model state
  logic [PCW-1:0] m_pc;
  logic           m_v;
  logic [IW-1:0]  m_ins;
  logic [8:0]     m_ctrl;
  logic [AW-1:0]  m_rt;

  task automatic run_case(input int pop, input int cop, input int mode, output int nstall);
    int rs, rt, rd;
    logic m_stall, exp_stall_once;
    rs = 11; rt = 12; rd = 13;
    case (mode)
      1: rs = 5;
      2: rt = 5;
      3: begin rs = 5; rt = 5; end
      4: rd = 5;
      default: ;
    endcase
    prog_prod = mk(pop, 3, 5, 5);
    prog_cons = mk(cop, rs, rt, rd);
    nstall = 0;
    rst = 1'b1;
    @(posedge clk); @(posedge clk);
    #1 rst = 1'b0;
    m_pc = 0; m_v = 0; m_ins = '0; m_ctrl = '0; m_rt = '0;
    @(negedge clk);
    chk("R8 reset pc", pc, 0);
    chk("R8 reset valid", id_valid, 0);
    chk("R8 reset ctrl", ex_ctrl, 0);
    for (int c = 0; c < RUN; c++) begin
      m_stall = m_ctrl[3] && m_v &&
                (m_rt == m_ins[2*AW +: AW] || m_rt == m_ins[AW +: AW]);
      if (m_stall) nstall++;
      if (m_stall) chk("R1 stall raised", czero, 1);
      else if (!m_ctrl[3]) chk("R2 no load no stall", czero, 0);
      else chk("R1 no match no stall", czero, 0);
      chk("R9 pc_we", pc_we, !m_stall);
      chk("R9 ifid_we", ifid_we, !m_stall);
      chk("R3 pc", pc, m_pc);
      chk("R4 ifid", {id_valid, id_instr}, {m_v, m_ins});
      chk("R7 ex ctrl", ex_ctrl, m_ctrl);
      chk("R7 ex rt", ex_rt, m_rt);
      // advance the model
      m_ctrl = m_stall ? 9'd0 : cw(m_v, m_ins[3*AW +: 2]);
      m_rt   = m_ins[AW +: AW];
      if (!m_stall) begin
        m_ins = (m_pc == 0) ? prog_prod : (m_pc == 4) ? prog_cons : mk(0, 28, 29, 30);
        m_v   = 1'b1;
        m_pc  = m_pc + 4;
      end
      @(negedge clk);
      if (m_stall) chk("R5 bubble", ex_ctrl, 0);
    end
    exp_stall_once = (pop == 1) && (mode >= 1) && (mode <= 3);
    chk("R6 stall count", nstall, exp_stall_once ? 1 : 0);
  endtask

  initial begin
    int ns;
    prog_prod = '0; prog_cons = '0;
    for (int p = 0; p < 2; p++)
      for (int c = 0; c < 4; c++)
        for (int m = 0; m < 5; m++)
          run_case(p, c, m, ns);
    done = 1;
  end

  initial begin
    for (int w = 0; w < 20000 && !done; w++) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule